// File: doc/BRIEF.md
# Predictor-Reactor Invariant Monitor

This block watches an untrusted unit from the outside while the chip runs. It does not look inside the unit. The unit that feeds work into the monitored unit (the predictor) pulses a one-bit strobe for every item it hands over. The unit that consumes the results (the reactor) pulses its own strobe for every item that comes out. In a healthy system these counts balance. The only gap allowed is a bounded number of items in flight inside the monitored pipeline. For example, a decoder should deliver to execution exactly as many instructions as fetch gave it.

The monitor keeps one up/down count of outstanding items. It raises an alarm in four cases:
- the count would go below zero;
- the count would go above the permitted pipeline slack;
- items stay outstanding for too long with no output;
- in the optional data-integrity variant, an output carries a type code that a mask register does not permit.

The alarm stays set until it is explicitly cleared. On the first violation the monitor latches, for later forensic reading:
- the reason for the alarm;
- the data word on the output side;
- the outstanding count.

It also raises a one-cycle request to the system to shut down.

Top module: `flow_guard`

## Requirements
- R1: After reset, `alarm`, `shutdown_req`, `log_cause`, `log_data` and `log_level` are all zero, and the type mask permits every type code.
- R2: While fewer than SLACK items are outstanding and the count never goes negative, matched predictor and reactor strobes never raise the alarm. A predictor strobe adds one to the outstanding count and a reactor strobe subtracts one. Both strobes in the same cycle leave the count unchanged.
- R3: A reactor strobe with no predictor strobe, in a cycle where the outstanding count is zero, is an underflow. The alarm is set after the next edge with `log_cause` bit 0 set.
- R4: Exactly SLACK outstanding items is legal. A predictor strobe with no reactor strobe while SLACK items are outstanding is an overflow, flagged in `log_cause` bit 1.
- R5: Suppose the outstanding count is nonzero and TIMEOUT consecutive cycles pass with no reactor strobe. The alarm is then set at the edge that ends the TIMEOUT-th such cycle, with `log_cause` bit 2 set.
- R6: When CHECK_TYPES is 1, a reactor strobe whose type code `react_data[TYPE_W-1:0]` = t finds bit t of the type mask clear, and this sets the alarm with `log_cause` bit 3. When CHECK_TYPES is 0, type codes never raise the alarm.
- R7: When `type_mask_we` is high, `type_mask_in` replaces the type mask at the clock edge. A reactor strobe in that same cycle is judged against the old mask.
- R8: On the first violating cycle while no alarm is set, `alarm` rises at the next edge. At that edge:
  - `log_cause` takes every cause bit flagged in that cycle;
  - `log_data` takes `react_data` of that cycle;
  - `log_level` takes the outstanding count held at the start of that cycle.

  All of these then hold, and later violations are ignored, until a clear.
- R9: `shutdown_req` is high for exactly the one cycle in which `alarm` first becomes high.
- R10: `alarm_clr` zeroes the alarm, the three log outputs, the outstanding count and the stall timer at the next edge. It takes priority over a violation in the same cycle and leaves the type mask unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_evt | input | 1 | One item handed into the monitored unit |
| react_evt | input | 1 | One item delivered by the monitored unit |
| react_data | input | DATA_W | Word delivered with the reactor strobe; low TYPE_W bits are its type code |
| type_mask_we | input | 1 | Load strobe for the permitted-type mask |
| type_mask_in | input | 2**TYPE_W | New mask; bit t set permits type code t |
| alarm_clr | input | 1 | Clears alarm, logs, outstanding count and stall timer |
| alarm | output | 1 | Sticky invariant-violation flag |
| shutdown_req | output | 1 | One-cycle shutdown request when the alarm first rises |
| log_cause | output | 4 | Causes latched: bit0 underflow, bit1 overflow, bit2 stall timeout, bit3 bad type |
| log_data | output | DATA_W | Reactor data word latched at the violation |
| log_level | output | clog2(SLACK+1) | Outstanding count latched at the violation |

## Verification
The bench builds two copies with SLACK = 4 and TIMEOUT = 16, one with the type screen and one without, driven by the same stimulus. The small slack lets a few strobes reach the overflow boundary and the exact-limit case. The short timeout lets the stall alarm be counted cycle by cycle. Running the second copy in parallel shows that the same bad type code alarms in one variant and stays silent in the other, and that a combined underflow and bad-type cycle latches different cause sets in the two copies.

// File: rtl/flow_guard_pkg.sv
`timescale 1ns/1ps
package flow_guard_pkg;
    localparam int CAUSE_W   = 4;
    localparam int CB_UNDER  = 0;
    localparam int CB_OVER   = 1;
    localparam int CB_STALL  = 2;
    localparam int CB_TYPE   = 3;
    typedef logic [CAUSE_W-1:0] cause_t;
endpackage

// File: rtl/fg_balance.sv
`timescale 1ns/1ps
// Outstanding-item counter between predictor and reactor strobes.
module fg_balance #(
    parameter int SLACK = 8,
    parameter int LVL_W = $clog2(SLACK + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    input  logic             hold,
    input  logic             clr,
    output logic [LVL_W-1:0] level,
    output logic             under,
    output logic             over
);
    localparam logic [LVL_W-1:0] LIMIT = LVL_W'(SLACK);

    typedef struct packed {
        logic [LVL_W-1:0] level;
    } bal_t;

    bal_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        under = dec && !inc && (st_q.level == '0);
        over  = inc && !dec && (st_q.level == LIMIT);
        if (clr) begin
            st_d.level = '0;
        end else if (!hold) begin
            if (inc && !dec) begin
                st_d.level = st_q.level + 1'b1;
            end else if (dec && !inc) begin
                st_d.level = st_q.level - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.level;
endmodule

// File: rtl/fg_stall_timer.sv
`timescale 1ns/1ps
// Counts consecutive cycles with items outstanding and no reactor output.
module fg_stall_timer #(
    parameter int TIMEOUT = 64,
    parameter int TMR_W   = $clog2(TIMEOUT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic drain,
    input  logic hold,
    input  logic clr,
    output logic expired
);
    localparam logic [TMR_W-1:0] LAST = TMR_W'(TIMEOUT - 1);

    typedef struct packed {
        logic [TMR_W-1:0] idle;
    } tmr_t;

    tmr_t st_d, st_q;
    logic stall;

    always_comb begin
        st_d    = st_q;
        stall   = pending && !drain;
        expired = stall && (st_q.idle == LAST);
        if (clr) begin
            st_d.idle = '0;
        end else if (!hold) begin
            st_d.idle = stall ? st_q.idle + 1'b1 : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/fg_type_screen.sv
`timescale 1ns/1ps
// Optional check of output type codes against a permitted-type mask.
module fg_type_screen #(
    parameter int                        TYPE_W    = 3,
    parameter int                        NTYPES    = 1 << TYPE_W,
    parameter bit                        CHECK     = 1'b1,
    parameter logic [NTYPES-1:0]         MASK_INIT = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [TYPE_W-1:0] type_code,
    input  logic              mask_we,
    input  logic [NTYPES-1:0] mask_in,
    output logic              reject
);
    generate
        if (CHECK) begin : g_screen
            typedef struct packed {
                logic [NTYPES-1:0] mask;
            } scr_t;

            scr_t st_d, st_q;

            always_comb begin
                st_d   = st_q;
                reject = strobe && !st_q.mask[type_code];
                if (mask_we) begin
                    st_d.mask = mask_in;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_q.mask <= MASK_INIT;
                end else begin
                    st_q <= st_d;
                end
            end
        end else begin : g_bypass
            logic unused_inputs;
            assign unused_inputs = ^{clk, rst_n, strobe, type_code, mask_we, mask_in};
            assign reject        = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/flow_guard.sv
`timescale 1ns/1ps
// Runtime invariant monitor: predictor strobes in must equal reactor strobes out.
module flow_guard
    import flow_guard_pkg::*;
#(
    parameter int                          SLACK          = 8,
    parameter int                          TIMEOUT        = 64,
    parameter int                          TYPE_W         = 3,
    parameter int                          DATA_W         = 16,
    parameter bit                          CHECK_TYPES    = 1'b1,
    parameter logic [(1 << TYPE_W)-1:0]    TYPE_MASK_INIT = '1,
    localparam int                         NTYPES         = 1 << TYPE_W,
    localparam int                         LVL_W          = $clog2(SLACK + 1),
    localparam int                         TMR_W          = $clog2(TIMEOUT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pred_evt,
    input  logic              react_evt,
    input  logic [DATA_W-1:0] react_data,
    input  logic              type_mask_we,
    input  logic [NTYPES-1:0] type_mask_in,
    input  logic              alarm_clr,
    output logic              alarm,
    output logic              shutdown_req,
    output logic [CAUSE_W-1:0] log_cause,
    output logic [DATA_W-1:0] log_data,
    output logic [LVL_W-1:0]  log_level
);
    typedef struct packed {
        logic              alarm;
        logic              shut;
        cause_t            cause;
        logic [DATA_W-1:0] data;
        logic [LVL_W-1:0]  level;
    } guard_t;

    guard_t st_d, st_q;

    logic [LVL_W-1:0] level_w;
    logic             under_w;
    logic             over_w;
    logic             expired_w;
    logic             reject_w;
    cause_t           viol_w;
    logic             bal_hold;

    always_comb begin
        viol_w           = '0;
        viol_w[CB_UNDER] = under_w;
        viol_w[CB_OVER]  = over_w;
        viol_w[CB_STALL] = expired_w;
        viol_w[CB_TYPE]  = reject_w;
    end

    assign bal_hold = st_q.alarm || (viol_w != '0);

    fg_balance #(
        .SLACK (SLACK),
        .LVL_W (LVL_W)
    ) u_balance (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (pred_evt),
        .dec   (react_evt),
        .hold  (bal_hold),
        .clr   (alarm_clr),
        .level (level_w),
        .under (under_w),
        .over  (over_w)
    );

    fg_stall_timer #(
        .TIMEOUT (TIMEOUT),
        .TMR_W   (TMR_W)
    ) u_stall (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (level_w != '0),
        .drain   (react_evt),
        .hold    (st_q.alarm),
        .clr     (alarm_clr),
        .expired (expired_w)
    );

    fg_type_screen #(
        .TYPE_W    (TYPE_W),
        .NTYPES    (NTYPES),
        .CHECK     (CHECK_TYPES),
        .MASK_INIT (TYPE_MASK_INIT)
    ) u_screen (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (react_evt),
        .type_code (react_data[TYPE_W-1:0]),
        .mask_we   (type_mask_we),
        .mask_in   (type_mask_in),
        .reject    (reject_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.shut = 1'b0;
        if (alarm_clr) begin
            st_d = '0;
        end else if (!st_q.alarm && (viol_w != '0)) begin
            st_d.alarm = 1'b1;
            st_d.shut  = 1'b1;
            st_d.cause = viol_w;
            st_d.data  = react_data;
            st_d.level = level_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alarm        = st_q.alarm;
    assign shutdown_req = st_q.shut;
    assign log_cause    = st_q.cause;
    assign log_data     = st_q.data;
    assign log_level    = st_q.level;
endmodule

// File: rtl/flow_guard_chk.sv
`timescale 1ns/1ps
module flow_guard_chk #(
    parameter int SLACK  = 8,
    parameter int LVL_W  = 4,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pred_evt,
    input logic              react_evt,
    input logic              alarm_clr,
    input logic              alarm,
    input logic              shutdown_req,
    input logic [3:0]        log_cause,
    input logic [DATA_W-1:0] log_data,
    input logic [LVL_W-1:0]  log_level,
    input logic [LVL_W-1:0]  level
);
    // R8
    alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm && !alarm_clr |=> alarm);

    // R8
    log_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm && !alarm_clr |=> $stable(log_data) && $stable(log_cause) && $stable(log_level));

    // R8
    cause_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |-> log_cause != 4'b0);

    // R9
    shutdown_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req == $rose(alarm));

    // R10
    clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_clr |=> !alarm && log_cause == 4'b0 && level == '0);

    // R3
    underflow_catch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        react_evt && !pred_evt && level == '0 && !alarm && !alarm_clr |=> alarm && log_cause[0]);

    // R4
    overflow_catch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_evt && !react_evt && level == LVL_W'(SLACK) && !alarm && !alarm_clr
        |=> alarm && log_cause[1]);

    // R4
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(SLACK));
endmodule

bind flow_guard flow_guard_chk #(
    .SLACK  (SLACK),
    .LVL_W  (LVL_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pred_evt     (pred_evt),
    .react_evt    (react_evt),
    .alarm_clr    (alarm_clr),
    .alarm        (alarm),
    .shutdown_req (shutdown_req),
    .log_cause    (log_cause),
    .log_data     (log_data),
    .log_level    (log_level),
    .level        (level_w)
);

// File: tb/sim_flow_guard.sv
`timescale 1ns/1ps
module sim_flow_guard;
    localparam int SLACK   = 4;
    localparam int TIMEOUT = 16;
    localparam int TYPE_W  = 3;
    localparam int DATA_W  = 16;
    localparam int NT      = 1 << TYPE_W;
    localparam int LVL_W   = $clog2(SLACK + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pred_evt = 1'b0, react_evt = 1'b0, mask_we = 1'b0, clr = 1'b0;
    logic [DATA_W-1:0] rdata = '0;
    logic [NT-1:0]     mask_in = '0;

    logic              a0, s0, a1, s1;
    logic [3:0]        c0, c1;
    logic [DATA_W-1:0] d0, d1;
    logic [LVL_W-1:0]  l0, l1;

    always #10 clk = ~clk;

    flow_guard #(.SLACK(SLACK), .TIMEOUT(TIMEOUT), .TYPE_W(TYPE_W), .DATA_W(DATA_W),
                 .CHECK_TYPES(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .pred_evt(pred_evt), .react_evt(react_evt),
        .react_data(rdata), .type_mask_we(mask_we), .type_mask_in(mask_in),
        .alarm_clr(clr), .alarm(a0), .shutdown_req(s0), .log_cause(c0),
        .log_data(d0), .log_level(l0));

    flow_guard #(.SLACK(SLACK), .TIMEOUT(TIMEOUT), .TYPE_W(TYPE_W), .DATA_W(DATA_W),
                 .CHECK_TYPES(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .pred_evt(pred_evt), .react_evt(react_evt),
        .react_data(rdata), .type_mask_we(mask_we), .type_mask_in(mask_in),
        .alarm_clr(clr), .alarm(a1), .shutdown_req(s1), .log_cause(c1),
        .log_data(d1), .log_level(l1));

    typedef struct {
        logic              alarm;
        logic              shut;
        logic [3:0]        cause;
        logic [DATA_W-1:0] data;
        logic [LVL_W-1:0]  level;
    } obs_t;

    typedef struct {
        obs_t  e0;
        obs_t  e1;
        string tag;
    } item_t;

    item_t q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit reported = 1'b0;

    // Reference state built from the requirements, one set per copy.
    int         m_lvl[2];
    int         m_idle[2];
    obs_t       m_out[2];
    logic [NT-1:0] m_mask;

    task automatic model_step(int k, bit chk, bit p, bit r, logic [DATA_W-1:0] d, bit c);
        bit under, over, stall, tmo, bad;
        logic [3:0] v;
        under = r && !p && (m_lvl[k] == 0);
        over  = p && !r && (m_lvl[k] == SLACK);
        stall = (m_lvl[k] != 0) && !r;
        tmo   = stall && (m_idle[k] == TIMEOUT - 1);
        bad   = chk && r && !m_mask[d[TYPE_W-1:0]];
        v     = {bad, tmo, over, under};
        m_out[k].shut = 1'b0;
        if (c) begin
            m_out[k] = '{1'b0, 1'b0, 4'b0, '0, '0};
            m_lvl[k] = 0;
            m_idle[k] = 0;
        end else if (!m_out[k].alarm) begin
            m_idle[k] = stall ? m_idle[k] + 1 : 0;
            if (v != 4'b0) begin
                m_out[k] = '{1'b1, 1'b1, v, d, LVL_W'(m_lvl[k])};
            end else begin
                m_lvl[k] = m_lvl[k] + int'(p) - int'(r);
            end
        end
    endtask

    task automatic cyc(bit p, bit r, logic [DATA_W-1:0] d, bit c, bit we,
                       logic [NT-1:0] mi, string tag);
        item_t it;
        @(negedge clk);
        pred_evt = p; react_evt = r; rdata = d; clr = c; mask_we = we; mask_in = mi;
        model_step(0, 1'b1, p, r, d, c);
        model_step(1, 1'b0, p, r, d, c);
        if (we) m_mask = mi;
        it.e0 = m_out[0];
        it.e1 = m_out[1];
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, '0, 1'b0, 1'b0, '0, tag);
    endtask

    task automatic compare(string who, string tag, obs_t act, obs_t exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: alarm=%b shut=%b cause=%b data=%h level=%0d, expected alarm=%b shut=%b cause=%b data=%h level=%0d",
                     tag, who, act.alarm, act.shut, act.cause, act.data, act.level,
                     exp.alarm, exp.shut, exp.cause, exp.data, exp.level);
        end
    endtask

    // Monitor: samples 5 ns after each rising edge and scores queued expectations.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                compare("u0", it.tag, '{a0, s0, c0, d0, l0}, it.e0);
                compare("u1", it.tag, '{a1, s1, c1, d1, l1}, it.e1);
            end
        end
    end

    task automatic finish_run();
        if (!reported) begin
            reported = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end

    initial begin
        obs_t zero;
        zero = '{1'b0, 1'b0, 4'b0, '0, '0};
        for (int k = 0; k < 2; k++) begin
            m_lvl[k] = 0; m_idle[k] = 0; m_out[k] = zero;
        end
        m_mask = '1;
        repeat (3) @(posedge clk);
        #5;
        // R1: reset state of both copies
        compare("u0", "R1 reset", '{a0, s0, c0, d0, l0}, zero);
        compare("u1", "R1 reset", '{a1, s1, c1, d1, l1}, zero);
        @(negedge clk);
        rst_n = 1'b1;

        // R1/R2: balanced traffic with mixed types under the reset mask
        cyc(1, 0, 16'h0011, 0, 0, '0, "R2 balance");
        cyc(1, 0, 16'h0012, 0, 0, '0, "R2 balance");
        cyc(1, 1, 16'h0022, 0, 0, '0, "R2 both strobes");
        cyc(0, 1, 16'h0035, 0, 0, '0, "R1 R2 drain");
        cyc(0, 1, 16'h0046, 0, 0, '0, "R1 R2 drain");
        idle(3, "R2 idle");
        // R4: exactly SLACK outstanding is legal
        for (int i = 0; i < SLACK; i++) cyc(1, 0, 16'h0000, 0, 0, '0, "R4 at limit");
        for (int i = 0; i < SLACK; i++) cyc(0, 1, 16'h0007, 0, 0, '0, "R4 at limit");

        // R3: underflow, then R8 logs held under later strobes, R9 pulse
        cyc(0, 1, 16'hBEE1, 0, 0, '0, "R3 R9 underflow");
        cyc(1, 0, 16'h1111, 0, 0, '0, "R8 held");
        cyc(0, 1, 16'h2222, 0, 0, '0, "R8 held");
        cyc(0, 1, 16'h3333, 0, 0, '0, "R8 held");
        cyc(0, 0, 16'h0000, 1, 0, '0, "R10 clear");
        idle(2, "R10 after clear");

        // R4: overflow at SLACK+1
        for (int i = 0; i < SLACK; i++) cyc(1, 0, 16'h0000, 0, 0, '0, "R4 fill");
        cyc(1, 0, 16'h0C07, 0, 0, '0, "R4 overflow");
        idle(2, "R8 held");
        cyc(0, 0, 16'h0000, 1, 0, '0, "R10 clear");

        // R5: stall timeout, exact edge scored every cycle
        cyc(1, 0, 16'h0000, 0, 0, '0, "R5 load");
        idle(TIMEOUT + 2, "R5 stall");
        cyc(0, 0, 16'h0000, 1, 0, '0, "R10 clear");
        // R5: a reactor strobe restarts the window
        cyc(1, 0, 16'h0000, 0, 0, '0, "R5 load");
        cyc(1, 0, 16'h0000, 0, 0, '0, "R5 load");
        idle(TIMEOUT - 2, "R5 window");
        cyc(0, 1, 16'h0001, 0, 0, '0, "R5 restart");
        idle(TIMEOUT - 2, "R5 window");
        cyc(0, 1, 16'h0001, 0, 0, '0, "R5 drain");

        // R7/R6: mask out type 3, then a balanced cycle carrying type 3
        cyc(0, 0, 16'h0000, 0, 1, 8'hF7, "R7 load mask");
        cyc(1, 1, 16'hAB03, 0, 0, '0, "R6 bad type");
        cyc(0, 0, 16'h0000, 1, 0, '0, "R10 clear keeps mask");
        // R7: mask write and strobe together use the old mask
        cyc(1, 1, 16'h0003, 0, 1, 8'hFF, "R7 old mask");
        cyc(0, 0, 16'h0000, 1, 0, '0, "R10 clear");
        cyc(1, 1, 16'h0003, 0, 0, '0, "R7 new mask");

        // R10: clear wins over a same-cycle underflow
        cyc(0, 1, 16'h0001, 1, 0, '0, "R10 priority");
        idle(2, "R10 priority");

        // R8: combined causes latched together
        cyc(0, 0, 16'h0000, 0, 1, 8'hF7, "R7 load mask");
        cyc(0, 1, 16'h5A03, 0, 0, '0, "R8 R6 combined");
        idle(2, "R8 held");
        cyc(0, 0, 16'h0000, 1, 0, '0, "R10 clear");
        idle(2, "R10 after clear");

        wait (q.size() == 0);
        @(posedge clk);
        #6;
        finish_run();
    end
endmodule